// File: doc/BRIEF.md
# SMBus Target Message Decoder

This block is the receive side of an SMBus target. A physical-layer front end, not part of this block, turns the SCL/SDA activity into single-cycle events: a START (or repeated START), a STOP, a received byte, and a request for the next byte the target has to send. The decoder follows these events and compares each address byte against a programmable own address. That address resets to a usable default, so the block works without any setup from software. For every received byte it returns an ACK or NACK decision.

The decoder accepts exactly three transfers. A Byte Write stores a command byte and a data byte. A Byte Read returns one byte of host-side state, selected by the command byte that came before the repeated START. A Host Notify goes to the fixed host address and carries a device byte and a 16-bit value. Each of the three counts only when a proper STOP closes it. A completed Host Notify sets the notify status bit; a completed Byte Write or Byte Read sets the general message bit instead. Both bits are sticky and are cleared by writing a 1.

The target neither appends nor expects a packet error code. A byte that arrives after the last byte of a message is refused, and the message is then dropped.

Top module: `smb_rx_decoder`

## Requirements
- R1: After reset the own address is DEF_ADDR (default 7'h44). Both status bits are 0, the command, data and notify registers are 0, and tx_data is 8'hFF.
- R2: A cycle with cfg_addr_we high loads cfg_addr into the own address, which is visible on own_addr one cycle later. The address bytes that follow are matched against the new value, and the old address is no longer matched.
- R3: Every byte event produces ack_vld one cycle later, with ack_ok=1 (ACK) for each byte that belongs to an accepted message.
- R4: An address byte whose upper 7 bits are neither the own address nor the notify address 7'h08 with R/W bit 0 is NACKed. Every later byte up to the next START is also NACKed, and neither status bit nor any register changes.
- R5: Byte Write is the address byte {own,0}, then a command byte, then a data byte, then STOP. At the STOP rx_cmd and rx_data take the two bytes and sts_msg is set.
- R6: Byte Read is {own,0}, a command byte, a repeated START, {own,1}, and then rd_req. One cycle after rd_req, tx_vld is high and tx_data is byte `cmd` of host_state (bits cmd*8+7 down to cmd*8) when cmd < NREG, and 8'hFF otherwise. A STOP after at least one byte has been sent sets sts_msg.
- R7: Host Notify is {7'h08,0}, then a device byte, a low data byte and a high data byte, then STOP. At the STOP hn_dev takes the device byte, hn_data takes {high,low} and sts_notify is set, while sts_msg is left unchanged. The notify address is checked before the own address.
- R8: A byte beyond the last byte of a message (for example a trailing error-check byte) is NACKed. The message is then discarded: at the STOP no status bit is set and no register changes.
- R9: A message that does not end in STOP is not counted: a START that arrives before the STOP discards it without any status or register change.
- R10: The status bits are sticky. sts_clr[0] clears sts_notify and sts_clr[1] clears sts_msg. A set and a clear in the same cycle leave the bit set.
- R11: An address byte {own,1} that does not directly follow a repeated START after {own,0} and a command byte is NACKed and sets no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr_we | input | 1 | Load strobe for the own address |
| cfg_addr | input | 7 | New own address |
| sts_clr | input | 2 | Write-1 clear: bit 0 notify, bit 1 message |
| host_state | input | NREG*8 | Bytes that a Byte Read can return |
| ev_start | input | 1 | START or repeated START seen |
| ev_stop | input | 1 | STOP seen |
| ev_byte | input | 1 | A byte has been received |
| ev_data | input | 8 | The received byte |
| rd_req | input | 1 | The master wants a byte from the target |
| own_addr | output | 7 | Current own address |
| ack_vld | output | 1 | ACK decision valid |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| tx_vld | output | 1 | Byte to send valid |
| tx_data | output | 8 | Byte to send |
| rx_cmd | output | 8 | Command byte of the last Byte Write |
| rx_data | output | 8 | Data byte of the last Byte Write |
| hn_dev | output | 8 | Device byte of the last Host Notify |
| hn_data | output | 16 | Data word of the last Host Notify |
| sts_notify | output | 1 | Sticky: a Host Notify completed |
| sts_msg | output | 1 | Sticky: a Byte Write or Byte Read completed |

## Verification
The assertions assume that at most one of ev_start, ev_stop, ev_byte and rd_req is high in any cycle, because the front end reports bus events one at a time. One property checks this assumption directly. The bench drives every event through a task that raises one strobe for exactly one cycle and lowers it again. rd_req is issued only after an address byte, and the own address is reprogrammed only between messages, so each property sees the event ordering a real front end would produce.

// File: rtl/smbrx_pkg.sv
// Package smbrx_pkg: shared types and constants of the SMBus target decoder.
// Assumes 8-bit bus bytes and a 7-bit address in the upper bits of an address byte.
package smbrx_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    // Address that receives host-notify messages, and the write-direction address byte for it
    localparam logic [ADDR_W-1:0] NOTIFY_ADDR = 7'h08;
    localparam logic [BYTE_W-1:0] NOTIFY_BYTE = {NOTIFY_ADDR, 1'b0};

    // Position of the decoder inside a message
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RSADDR,
        ST_CMD,
        ST_WDATA,
        ST_WDONE,
        ST_RD,
        ST_RDSENT,
        ST_HDEV,
        ST_HLO,
        ST_HHI,
        ST_HDONE,
        ST_IGN
    } seq_state_t;

    // One-cycle completion strobes, raised when a STOP closes a well-formed message
    typedef struct packed {
        logic wr;
        logic rd;
        logic hn;
    } commit_t;

endpackage

// File: rtl/smbrx_seq.sv
// Module smbrx_seq: message sequencer. It follows the start/stop/byte/read events,
// decides ACK or NACK for each byte, captures the bytes of the message in progress
// and raises a commit strobe when a STOP closes a complete message.
// Assumes that at most one event strobe is high in any cycle.
module smbrx_seq
    import smbrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [BYTE_W-1:0] ev_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic              rd_phase,
    output commit_t           commit,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] dat_q,
    output logic [BYTE_W-1:0] hdev_q,
    output logic [BYTE_W-1:0] hlo_q,
    output logic [BYTE_W-1:0] hhi_q
);

    seq_state_t        st, st_nxt;
    logic              accept;
    logic [ADDR_W-1:0] in_addr;
    logic              in_rd;
    logic              own_hit;

    assign in_addr = ev_data[BYTE_W-1:1];
    assign in_rd   = ev_data[0];
    assign own_hit = (in_addr == own_addr);

    // Next position in the message and ACK decision for the current event
    always_comb begin
        st_nxt = st;
        accept = 1'b0;
        if (ev_start) begin
            st_nxt = (st == ST_WDATA) ? ST_RSADDR : ST_ADDR;
        end else if (ev_stop) begin
            st_nxt = ST_IDLE;
        end else if (ev_byte) begin
            st_nxt = ST_IGN;
            case (st)
                ST_ADDR, ST_RSADDR: begin
                    if (ev_data == NOTIFY_BYTE) begin
                        st_nxt = ST_HDEV;
                        accept = 1'b1;
                    end else if (own_hit && !in_rd) begin
                        st_nxt = ST_CMD;
                        accept = 1'b1;
                    end else if (own_hit && in_rd && st == ST_RSADDR) begin
                        st_nxt = ST_RD;
                        accept = 1'b1;
                    end
                end
                ST_CMD:   begin st_nxt = ST_WDATA; accept = 1'b1; end
                ST_WDATA: begin st_nxt = ST_WDONE; accept = 1'b1; end
                ST_HDEV:  begin st_nxt = ST_HLO;   accept = 1'b1; end
                ST_HLO:   begin st_nxt = ST_HHI;   accept = 1'b1; end
                ST_HHI:   begin st_nxt = ST_HDONE; accept = 1'b1; end
                default:  begin st_nxt = ST_IGN;   accept = 1'b0; end
            endcase
        end else if (rd_req && st == ST_RD) begin
            st_nxt = ST_RDSENT;
        end
    end

    // Completion strobes: only a STOP in a finished state counts
    always_comb begin
        commit.wr = ev_stop && !ev_start && (st == ST_WDONE);
        commit.rd = ev_stop && !ev_start && (st == ST_RDSENT);
        commit.hn = ev_stop && !ev_start && (st == ST_HDONE);
    end

    assign rd_phase = (st == ST_RD) || (st == ST_RDSENT);

    // State register and ACK response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ack_vld <= 1'b0;
            ack_ok  <= 1'b0;
        end else begin
            st      <= st_nxt;
            ack_vld <= ev_byte;
            ack_ok  <= ev_byte && accept;
        end
    end

    // Capture of the payload bytes of the message in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            dat_q  <= '0;
            hdev_q <= '0;
            hlo_q  <= '0;
            hhi_q  <= '0;
        end else if (ev_byte && !ev_start && !ev_stop) begin
            case (st)
                ST_CMD:   cmd_q  <= ev_data;
                ST_WDATA: dat_q  <= ev_data;
                ST_HDEV:  hdev_q <= ev_data;
                ST_HLO:   hlo_q  <= ev_data;
                ST_HHI:   hhi_q  <= ev_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/smbrx_regs.sv
// Module smbrx_regs: host-visible registers of the decoder. It holds the own address
// (reset to a default), the committed write and notify payloads, and the two sticky
// write-1-clear status bits.
// Assumes that commit strobes are single-cycle and that the captured bytes are stable
// in the cycle of the strobe.
module smbrx_regs
    import smbrx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEF_ADDR = 7'h44
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_addr_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [1:0]          sts_clr,
    input  commit_t             commit,
    input  logic [BYTE_W-1:0]   cmd_q,
    input  logic [BYTE_W-1:0]   dat_q,
    input  logic [BYTE_W-1:0]   hdev_q,
    input  logic [BYTE_W-1:0]   hlo_q,
    input  logic [BYTE_W-1:0]   hhi_q,
    output logic [ADDR_W-1:0]   own_addr,
    output logic [BYTE_W-1:0]   rx_cmd,
    output logic [BYTE_W-1:0]   rx_data,
    output logic [BYTE_W-1:0]   hn_dev,
    output logic [2*BYTE_W-1:0] hn_data,
    output logic                sts_notify,
    output logic                sts_msg
);

    // Own address register, loaded by the host
    always_ff @(posedge clk) begin
        if (!rst_n)           own_addr <= DEF_ADDR;
        else if (cfg_addr_we) own_addr <= cfg_addr;
    end

    // Committed Byte Write payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cmd  <= '0;
            rx_data <= '0;
        end else if (commit.wr) begin
            rx_cmd  <= cmd_q;
            rx_data <= dat_q;
        end
    end

    // Committed Host Notify payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hn_dev  <= '0;
            hn_data <= '0;
        end else if (commit.hn) begin
            hn_dev  <= hdev_q;
            hn_data <= {hhi_q, hlo_q};
        end
    end

    // Sticky status bits, where a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_notify <= 1'b0;
            sts_msg    <= 1'b0;
        end else begin
            sts_notify <= commit.hn | (sts_notify & ~sts_clr[0]);
            sts_msg    <= commit.wr | commit.rd | (sts_msg & ~sts_clr[1]);
        end
    end

endmodule

// File: rtl/smbrx_rdmux.sv
// Module smbrx_rdmux: response byte for Byte Read. It selects the host_state byte that
// the command byte indexes, or 8'hFF when the index is out of range or no read is open.
// Assumes that the command byte is held stable for the whole read phase.
module smbrx_rdmux
    import smbrx_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_req,
    input  logic                   rd_phase,
    input  logic [BYTE_W-1:0]      cmd,
    input  logic [NREG*BYTE_W-1:0] host_state,
    output logic                   tx_vld,
    output logic [BYTE_W-1:0]      tx_data
);

    localparam logic [BYTE_W-1:0] FILL = '1;

    logic [NREG-1:0]   hit;
    logic [BYTE_W-1:0] masked [NREG];
    logic [BYTE_W-1:0] pick;

    // One comparator and one gated byte lane for each selectable register
    for (genvar i = 0; i < NREG; i++) begin : g_lane
        assign hit[i]    = (cmd == BYTE_W'(i));
        assign masked[i] = hit[i] ? host_state[i*BYTE_W +: BYTE_W] : '0;
    end

    // OR the gated lanes together, and fall back to the fill byte when no lane hits
    always_comb begin
        pick = (|hit) ? '0 : FILL;
        for (int k = 0; k < NREG; k++) pick = pick | masked[k];
    end

    // Response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_vld  <= 1'b0;
            tx_data <= FILL;
        end else begin
            tx_vld  <= rd_req;
            tx_data <= (rd_req && rd_phase) ? pick : FILL;
        end
    end

endmodule

// File: rtl/smb_rx_decoder.sv
// Module smb_rx_decoder: top of the SMBus target message decoder. It connects the
// sequencer, the host-visible registers and the read-response selector.
// Assumes a front end that reports each bus event as a single-cycle strobe.
module smb_rx_decoder
    import smbrx_pkg::*;
#(
    parameter logic [6:0] DEF_ADDR = 7'h44,
    parameter int         NREG     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_addr_we,
    input  logic [6:0]      cfg_addr,
    input  logic [1:0]      sts_clr,
    input  logic [NREG*8-1:0] host_state,
    input  logic            ev_start,
    input  logic            ev_stop,
    input  logic            ev_byte,
    input  logic [7:0]      ev_data,
    input  logic            rd_req,
    output logic [6:0]      own_addr,
    output logic            ack_vld,
    output logic            ack_ok,
    output logic            tx_vld,
    output logic [7:0]      tx_data,
    output logic [7:0]      rx_cmd,
    output logic [7:0]      rx_data,
    output logic [7:0]      hn_dev,
    output logic [15:0]     hn_data,
    output logic            sts_notify,
    output logic            sts_msg
);

    commit_t           commit;
    logic              rd_phase;
    logic [BYTE_W-1:0] cmd_q, dat_q, hdev_q, hlo_q, hhi_q;

    smbrx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_byte  (ev_byte),
        .ev_data  (ev_data),
        .rd_req   (rd_req),
        .own_addr (own_addr),
        .ack_vld  (ack_vld),
        .ack_ok   (ack_ok),
        .rd_phase (rd_phase),
        .commit   (commit),
        .cmd_q    (cmd_q),
        .dat_q    (dat_q),
        .hdev_q   (hdev_q),
        .hlo_q    (hlo_q),
        .hhi_q    (hhi_q)
    );

    smbrx_regs #(.DEF_ADDR(DEF_ADDR)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_addr_we (cfg_addr_we),
        .cfg_addr    (cfg_addr),
        .sts_clr     (sts_clr),
        .commit      (commit),
        .cmd_q       (cmd_q),
        .dat_q       (dat_q),
        .hdev_q      (hdev_q),
        .hlo_q       (hlo_q),
        .hhi_q       (hhi_q),
        .own_addr    (own_addr),
        .rx_cmd      (rx_cmd),
        .rx_data     (rx_data),
        .hn_dev      (hn_dev),
        .hn_data     (hn_data),
        .sts_notify  (sts_notify),
        .sts_msg     (sts_msg)
    );

    smbrx_rdmux #(.NREG(NREG)) u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .rd_phase   (rd_phase),
        .cmd        (cmd_q),
        .host_state (host_state),
        .tx_vld     (tx_vld),
        .tx_data    (tx_data)
    );

endmodule

// File: rtl/smbrx_chk.sv
// Module smbrx_chk: temporal properties of the decoder, observed at its ports.
// Assumes a synchronous active-low reset held for at least two clock edges.
module smbrx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_start,
    input logic        ev_stop,
    input logic        ev_byte,
    input logic        rd_req,
    input logic [1:0]  sts_clr,
    input logic        ack_vld,
    input logic        tx_vld,
    input logic [7:0]  rx_cmd,
    input logic [7:0]  rx_data,
    input logic [7:0]  hn_dev,
    input logic [15:0] hn_data,
    input logic        sts_notify,
    input logic        sts_msg
);

    // Input contract: the front end reports one event at a time (R3)
    p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_byte, rd_req}));

    // R3: every byte gets a decision in the following cycle, and nothing else does
    p_ack_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte |=> ack_vld);
    p_no_stray_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_byte |=> !ack_vld);

    // R6: a response byte is offered exactly one cycle after each read request
    p_tx_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> tx_vld);
    p_no_stray_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !tx_vld);

    // R5: the write payload changes only at a STOP
    p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ev_stop) |-> ($stable(rx_data) && $stable(rx_cmd)));

    // R7: the notify payload changes only at a STOP, and the flag rises only there
    p_notify_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ev_stop) |-> ($stable(hn_dev) && $stable(hn_data)));
    p_notify_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_notify) |-> $past(ev_stop));

    // R9: a message is counted only when a STOP closes it
    p_msg_on_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_msg) |-> $past(ev_stop));

    // R10: the bits stay set until cleared, and a clear without a STOP takes effect
    p_notify_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_notify && !sts_clr[0]) |=> sts_notify);
    p_msg_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_msg && !sts_clr[1]) |=> sts_msg);
    p_notify_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr[0] && !ev_stop) |=> !sts_notify);
    p_msg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr[1] && !ev_stop) |=> !sts_msg);

endmodule

bind smb_rx_decoder smbrx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_byte    (ev_byte),
    .rd_req     (rd_req),
    .sts_clr    (sts_clr),
    .ack_vld    (ack_vld),
    .tx_vld     (tx_vld),
    .rx_cmd     (rx_cmd),
    .rx_data    (rx_data),
    .hn_dev     (hn_dev),
    .hn_data    (hn_data),
    .sts_notify (sts_notify),
    .sts_msg    (sts_msg)
);

// File: tb/sim_smb_rx_decoder.sv
// Bench for smb_rx_decoder: behavioural message model, compared on every clock.
`timescale 1ns/1ps
module sim_smb_rx_decoder;

    localparam int NREG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_addr_we = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [1:0] sts_clr = '0;
    logic [NREG*8-1:0] host_state = 32'hD4C3B2A1;
    logic ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0, rd_req = 1'b0;
    logic [7:0] ev_data = '0;
    logic [6:0] own_addr;
    logic ack_vld, ack_ok, tx_vld, sts_notify, sts_msg;
    logic [7:0] tx_data, rx_cmd, rx_data, hn_dev;
    logic [15:0] hn_data;

    smb_rx_decoder #(.DEF_ADDR(7'h44), .NREG(NREG)) u0 (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0] cur[$];
    bit in_msg, bad, sent, prev_ok;
    logic [7:0] prev_cmd;
    logic [6:0] e_own = 7'h44;
    logic e_ack_vld, e_ack_ok, e_tx_vld, e_fn, e_fm;
    logic [7:0] e_tx = 8'hFF, e_cmd, e_data, e_hdev;
    logic [15:0] e_hdata;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        cur.delete(); in_msg = 0; bad = 0; sent = 0; prev_ok = 0; prev_cmd = 0;
        e_own = 7'h44; e_ack_vld = 0; e_ack_ok = 0; e_tx_vld = 0; e_tx = 8'hFF;
        e_cmd = 0; e_data = 0; e_hdev = 0; e_hdata = 0; e_fn = 0; e_fm = 0;
    endtask

    // Model of one clock edge, from the inputs held across it
    task automatic model_edge();
        logic [7:0] ow, orr;
        bit set_n, set_m, ok;
        ow = {e_own, 1'b0}; orr = {e_own, 1'b1};
        set_n = 0; set_m = 0;
        e_ack_vld = ev_byte; e_ack_ok = 0; e_tx_vld = rd_req; e_tx = 8'hFF;
        if (ev_start) begin
            prev_ok = in_msg && !bad && cur.size() == 2 && cur[0] == ow && cur[0] != 8'h10;
            if (prev_ok) prev_cmd = cur[1];
            cur.delete(); bad = 0; sent = 0; in_msg = 1;
        end else if (ev_stop) begin
            if (in_msg && !bad && cur.size() > 0) begin
                if (cur[0] == 8'h10 && cur.size() == 4) begin
                    set_n = 1; e_hdev = cur[1]; e_hdata = {cur[3], cur[2]};
                end else if (cur[0] == ow && cur.size() == 3) begin
                    set_m = 1; e_cmd = cur[1]; e_data = cur[2];
                end else if (cur[0] == orr && cur.size() == 1 && sent) begin
                    set_m = 1;
                end
            end
            cur.delete(); in_msg = 0; bad = 0; sent = 0; prev_ok = 0;
        end else if (ev_byte) begin
            ok = 0;
            if (in_msg && !bad) begin
                if (cur.size() == 0) ok = (ev_data == 8'h10) || (ev_data == ow) || (ev_data == orr && prev_ok);
                else if (cur[0] == 8'h10) ok = cur.size() <= 3;
                else if (cur[0] == ow) ok = cur.size() <= 2;
            end
            cur.push_back(ev_data);
            if (!ok) bad = 1;
            e_ack_ok = ok;
        end else if (rd_req) begin
            if (in_msg && !bad && cur.size() == 1 && cur[0] == orr) begin
                sent = 1;
                e_tx = (prev_cmd < NREG) ? host_state[prev_cmd*8 +: 8] : 8'hFF;
            end
        end
        e_fn = set_n | (e_fn & ~sts_clr[0]);
        e_fm = set_m | (e_fm & ~sts_clr[1]);
        if (cfg_addr_we) e_own = cfg_addr;
    endtask

    task automatic compare_all();
        chk("R2", "own_addr", 32'(own_addr), 32'(e_own));
        chk("R3", "ack_vld", 32'(ack_vld), 32'(e_ack_vld));
        chk("R3", "ack_ok", 32'(ack_ok), 32'(e_ack_ok));
        chk("R6", "tx_vld", 32'(tx_vld), 32'(e_tx_vld));
        chk("R6", "tx_data", 32'(tx_data), 32'(e_tx));
        chk("R5", "rx_cmd", 32'(rx_cmd), 32'(e_cmd));
        chk("R5", "rx_data", 32'(rx_data), 32'(e_data));
        chk("R7", "hn_dev", 32'(hn_dev), 32'(e_hdev));
        chk("R7", "hn_data", 32'(hn_data), 32'(e_hdata));
        chk("R10", "sts_notify", 32'(sts_notify), 32'(e_fn));
        chk("R10", "sts_msg", 32'(sts_msg), 32'(e_fm));
    endtask

    // One clock: inputs were set at the previous falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        ev_start = 0; ev_stop = 0; ev_byte = 0; rd_req = 0; sts_clr = 0; cfg_addr_we = 0;
    endtask

    task automatic do_start(); ev_start = 1; step(); endtask
    task automatic do_stop(input logic [1:0] clr); ev_stop = 1; sts_clr = clr; step(); endtask
    task automatic do_byte(input logic [7:0] b); ev_byte = 1; ev_data = b; step(); endtask
    task automatic do_read(); rd_req = 1; step(); endtask
    task automatic do_clear(input logic [1:0] clr); sts_clr = clr; step(); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare_all();
        // R1: reset values
        chk("R1", "own_addr default", 32'(own_addr), 32'h44);
        chk("R1", "status after reset", 32'({sts_notify, sts_msg}), 32'h0);
        chk("R1", "tx_data after reset", 32'(tx_data), 32'hFF);

        // R5: Byte Write to the default address
        do_start(); do_byte(8'h88); do_byte(8'h05); do_byte(8'h5A);
        chk("R3", "ack of write data", 32'(ack_ok), 32'h1);
        chk("R5", "no flag before stop", 32'(sts_msg), 32'h0);
        do_stop(2'b00);
        chk("R5", "rx_data after write", 32'(rx_data), 32'h5A);
        chk("R5", "rx_cmd after write", 32'(rx_cmd), 32'h05);
        chk("R5", "sts_msg after write", 32'(sts_msg), 32'h1);
        do_clear(2'b10);
        chk("R10", "sts_msg cleared", 32'(sts_msg), 32'h0);

        // R6: Byte Read of an in-range and an out-of-range command
        do_start(); do_byte(8'h88); do_byte(8'h02); do_start(); do_byte(8'h89);
        chk("R6", "ack of read address", 32'(ack_ok), 32'h1);
        do_read();
        chk("R6", "tx_data for cmd 2", 32'(tx_data), 32'hC3);
        do_stop(2'b00);
        chk("R6", "sts_msg after read", 32'(sts_msg), 32'h1);
        do_clear(2'b10);
        do_start(); do_byte(8'h88); do_byte(8'h09); do_start(); do_byte(8'h89); do_read();
        chk("R6", "tx_data out of range", 32'(tx_data), 32'hFF);
        do_stop(2'b10);
        chk("R10", "set wins over clear", 32'(sts_msg), 32'h1);
        do_clear(2'b10);

        // R7: Host Notify
        do_start(); do_byte(8'h10); do_byte(8'h88); do_byte(8'h34); do_byte(8'h12); do_stop(2'b00);
        chk("R7", "hn_data", 32'(hn_data), 32'h1234);
        chk("R7", "hn_dev", 32'(hn_dev), 32'h88);
        chk("R7", "sts_notify set, sts_msg not", 32'({sts_notify, sts_msg}), 32'h2);
        do_clear(2'b01);
        chk("R10", "sts_notify cleared", 32'(sts_notify), 32'h0);

        // R4: address that is not ours
        do_start(); do_byte(8'h66);
        chk("R4", "nack foreign address", 32'(ack_ok), 32'h0);
        do_byte(8'h05);
        chk("R4", "nack following byte", 32'(ack_ok), 32'h0);
        do_byte(8'h77); do_stop(2'b00);
        chk("R4", "no status for foreign", 32'({sts_notify, sts_msg}), 32'h0);
        chk("R4", "rx_data untouched", 32'(rx_data), 32'h5A);

        // R8: trailing byte after a complete write
        do_start(); do_byte(8'h88); do_byte(8'h06); do_byte(8'hA5); do_byte(8'hEE);
        chk("R8", "nack trailing byte", 32'(ack_ok), 32'h0);
        do_stop(2'b00);
        chk("R8", "write discarded", 32'(rx_data), 32'h5A);
        chk("R8", "no flag", 32'(sts_msg), 32'h0);
        // R8: trailing byte after a notify
        do_start(); do_byte(8'h10); do_byte(8'h11); do_byte(8'h22); do_byte(8'h33); do_byte(8'h44); do_stop(2'b00);
        chk("R8", "notify discarded", 32'({sts_notify, hn_data}), 32'h1234);

        // R9: START before STOP abandons the write
        do_start(); do_byte(8'h88); do_byte(8'h07); do_byte(8'h3C); do_start(); do_stop(2'b00);
        chk("R9", "no flag without stop", 32'(sts_msg), 32'h0);
        chk("R9", "rx_data unchanged", 32'(rx_data), 32'h5A);
        // R9: stop after only a command
        do_start(); do_byte(8'h88); do_byte(8'h07); do_stop(2'b00);
        chk("R9", "command only not counted", 32'(sts_msg), 32'h0);

        // R11: read address without a preceding command
        do_start(); do_byte(8'h89);
        chk("R11", "nack read without command", 32'(ack_ok), 32'h0);
        do_read(); do_stop(2'b00);
        chk("R11", "no status", 32'(sts_msg), 32'h0);

        // R2: program a new own address
        cfg_addr = 7'h21; cfg_addr_we = 1; step();
        chk("R2", "own_addr updated", 32'(own_addr), 32'h21);
        do_start(); do_byte(8'h88);
        chk("R2", "old address refused", 32'(ack_ok), 32'h0);
        do_stop(2'b00);
        do_start(); do_byte(8'h42); do_byte(8'h01); do_byte(8'hC7); do_stop(2'b00);
        chk("R2", "write to new address", 32'(rx_data), 32'hC7);
        chk("R5", "flag for new address", 32'(sts_msg), 32'h1);

        repeat (3) step();
        finish_run();
    end

endmodule